// File: doc/BRIEF.md
# Configuration Space Address Decoder

This block turns a configuration request, given as bus, slot, function and register numbers, into a byte offset inside a memory-mapped configuration window. It then performs a single 1, 2 or 4 byte access on a simple downstream memory port. The downstream address is word aligned. Byte enables select the lanes, and data is little-endian by lane. Read data comes back right-justified.

Bus 0 is treated with care. A request there only reaches the downstream port when its slot has been marked populated and its function number is zero. Any other request on bus 0 is answered inside the block: a read returns all ones and a write is discarded. A separate input marks populated slots one at a time. Secondary buses are mapped into a distinct address region above the bus-0 region.

Only one request is in flight at a time. The requester presents a request for one cycle while the block is idle, then waits for the one-cycle done pulse.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset `rsp_done_o` and `mem_req_o` are low and every slot is unpopulated, so a bus-0 read returns 0xFFFFFFFF with no downstream access.
- R2: For bus 0 the byte offset is {slot[4:0], func[2:0], reg[7:0]}, so the slot sits at bit 11 and the function at bit 8. `mem_addr_o` is that offset with bits 1:0 cleared.
- R3: For a non-zero bus the offset additionally gets 0x01000000 plus the bus number shifted left by 16, and no populated check applies.
- R4: A bus-0 read to an unpopulated slot or to a non-zero function returns 0xFFFFFFFF and raises no `mem_req_o`.
- R5: A bus-0 write to an unpopulated slot or to a non-zero function raises no `mem_req_o` and is dropped.
- R6: Pulsing `pop_set_i` with `pop_slot_i` marks exactly that slot populated. The mark is permanent until reset and leaves other slots unchanged.
- R7: `req_size_i` holds the byte count. For size 1, `mem_be_o` has bit reg[1:0] set. For size 2 it is 0b0011 shifted by reg[1:0]. For size 4 it is 0b1111. Write data byte k appears on `mem_wdata_o` bits 8k+7:8k, with k = reg[1:0] + i for byte i of the request.
- R8: Read data is taken from the enabled lanes of `mem_rdata_i`, shifted down to bit 0, with the bits above the access width cleared.
- R9: A size other than 1, 2 or 4, a size-2 access with reg[0] set, or a size-4 access with reg[1:0] non-zero is answered locally. A read returns 0xFFFFFFFF and a write is dropped; neither raises `mem_req_o`.
- R10: `rsp_done_o` is a one-cycle pulse. It comes in the cycle after the request for locally answered requests, and in the cycle after `mem_ack_i` for forwarded ones. `mem_req_o` and its address stay stable until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle, only while idle |
| req_bus_i | input | BUS_W | Bus number |
| req_slot_i | input | SLOT_W | Slot number |
| req_func_i | input | FUNC_W | Function number |
| req_reg_i | input | REG_W | Register byte offset |
| req_size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Right-justified write data |
| rsp_rdata_o | output | 32 | Right-justified read data, valid with done |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| pop_set_i | input | 1 | Mark the slot on pop_slot_i populated |
| pop_slot_i | input | SLOT_W | Slot to mark |
| mem_req_o | output | 1 | Downstream access request, held until ack |
| mem_addr_o | output | ADDR_W | Word-aligned window offset |
| mem_we_o | output | 1 | Downstream write enable |
| mem_be_o | output | 4 | Downstream byte enables |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| mem_ack_i | input | 1 | Downstream access complete |
| mem_rdata_i | input | 32 | Downstream read data, valid with ack |

## Verification
The bench builds the block with its default parameters: 8-bit bus, 5-bit slot, 3-bit function, 8-bit register and a 32-bit window offset. At that size every slot and function pairing on bus 0 can be swept, both before and after half the slots are populated. Every one of the 255 secondary buses is also covered. Every size code from 0 to 7 is combined with every low register offset, for reads and writes alike. The downstream model returns data derived from the address, so lane selection and right-justification are checked for every legal combination.

// File: rtl/cfgdec_pkg.sv
`timescale 1ns/1ps
package cfgdec_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic [3:0]  be;
    logic [1:0]  lane;
    logic [31:0] mask;
    logic        ok;
  } size_dec_t;

  function automatic size_dec_t decode_size(input logic [2:0] size, input logic [1:0] lane);
    size_dec_t d;
    d.lane = lane;
    d.be   = 4'b0000;
    d.mask = 32'h0;
    d.ok   = 1'b0;
    case (size)
      3'd1: begin d.ok = 1'b1;           d.be = 4'b0001 << lane; d.mask = 32'h0000_00ff; end
      3'd2: begin d.ok = ~lane[0];       d.be = 4'b0011 << lane; d.mask = 32'h0000_ffff; end
      3'd4: begin d.ok = (lane == 2'd0); d.be = 4'b1111;         d.mask = 32'hffff_ffff; end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/cfgdec_slot_map.sv
`timescale 1ns/1ps
module cfgdec_slot_map #(
  parameter int SLOT_W = 5,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SLOTS-1:0]  pop_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   pop_o[s] <= 1'b0;
      else if (set_i && (slot_i == SLOT_W'(s)))      pop_o[s] <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgdec_addr_gen.sv
`timescale 1ns/1ps
module cfgdec_addr_gen
  import cfgdec_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int SLOT_W  = 5,
  parameter int FUNC_W  = 3,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int SEC_BIT = 24,
  localparam int SLOTS  = 1 << SLOT_W,
  localparam int OFF_W  = SLOT_W + FUNC_W + REG_W
) (
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [2:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic [SLOTS-1:0]  pop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        be_o,
  output logic [31:0]       wdata_o,
  output logic [1:0]        lane_o,
  output logic [31:0]       mask_o,
  output logic              local_o
);
  logic [ADDR_W-1:0] base_off, full_off;
  logic              on_root, blocked;
  size_dec_t         sd;

  assign on_root  = (bus_i == '0);
  assign base_off = ADDR_W'({slot_i, func_i, reg_i});
  assign full_off = on_root ? base_off
                            : base_off + (ADDR_W'(1) << SEC_BIT) + (ADDR_W'(bus_i) << OFF_W);
  assign addr_o   = {full_off[ADDR_W-1:2], 2'b00};

  assign sd      = decode_size(size_i, reg_i[1:0]);
  assign be_o    = sd.be;
  assign lane_o  = sd.lane;
  assign mask_o  = sd.mask;
  assign wdata_o = wdata_i << {sd.lane, 3'b000};

  // root bus only talks to populated slots, function 0
  assign blocked = on_root && (!pop_i[slot_i] || (func_i != '0));
  assign local_o = blocked || !sd.ok;
endmodule

// File: rtl/cfgdec_seq.sv
`timescale 1ns/1ps
module cfgdec_seq
  import cfgdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              local_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        lane_i,
  input  logic [31:0]       mask_i,
  output logic [31:0]       rdata_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  seq_state_e  state_q;
  logic [1:0]  lane_q;
  logic [31:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      done_o      <= 1'b0;
      rdata_o     <= '0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      lane_q      <= '0;
      mask_q      <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (local_i) begin
            done_o  <= 1'b1;
            rdata_o <= req_write_i ? 32'h0 : 32'hffff_ffff;
          end else begin
            state_q     <= ST_WAIT;
            mem_req_o   <= 1'b1;
            mem_addr_o  <= addr_i;
            mem_we_o    <= req_write_i;
            mem_be_o    <= be_i;
            mem_wdata_o <= wdata_i;
            lane_q      <= lane_i;
            mask_q      <= mask_i;
          end
        end
        ST_WAIT: if (mem_ack_i) begin
          state_q   <= ST_IDLE;
          mem_req_o <= 1'b0;
          done_o    <= 1'b1;
          rdata_o   <= mem_we_o ? 32'h0 : ((mem_rdata_i >> {lane_q, 3'b000}) & mask_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_decoder.sv
`timescale 1ns/1ps
module cfg_window_decoder #(
  parameter int BUS_W   = 8,
  parameter int SLOT_W  = 5,
  parameter int FUNC_W  = 3,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int SEC_BIT = 24,
  localparam int SLOTS  = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic [FUNC_W-1:0] req_func_i,
  input  logic [REG_W-1:0]  req_reg_i,
  input  logic [2:0]        req_size_i,
  input  logic              req_write_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_done_o,
  input  logic              pop_set_i,
  input  logic [SLOT_W-1:0] pop_slot_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  logic [SLOTS-1:0]  pop_vec;
  logic [ADDR_W-1:0] dec_addr;
  logic [3:0]        dec_be;
  logic [31:0]       dec_wdata, dec_mask;
  logic [1:0]        dec_lane;
  logic              dec_local;

  cfgdec_slot_map #(.SLOT_W(SLOT_W)) i_slot_map (
    .clk_i, .rst_ni,
    .set_i (pop_set_i),
    .slot_i(pop_slot_i),
    .pop_o (pop_vec)
  );

  cfgdec_addr_gen #(
    .BUS_W(BUS_W), .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .SEC_BIT(SEC_BIT)
  ) i_addr_gen (
    .bus_i  (req_bus_i),
    .slot_i (req_slot_i),
    .func_i (req_func_i),
    .reg_i  (req_reg_i),
    .size_i (req_size_i),
    .wdata_i(req_wdata_i),
    .pop_i  (pop_vec),
    .addr_o (dec_addr),
    .be_o   (dec_be),
    .wdata_o(dec_wdata),
    .lane_o (dec_lane),
    .mask_o (dec_mask),
    .local_o(dec_local)
  );

  cfgdec_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i, .rst_ni,
    .req_valid_i,
    .req_write_i,
    .local_i    (dec_local),
    .addr_i     (dec_addr),
    .be_i       (dec_be),
    .wdata_i    (dec_wdata),
    .lane_i     (dec_lane),
    .mask_i     (dec_mask),
    .rdata_o    (rsp_rdata_o),
    .done_o     (rsp_done_o),
    .mem_req_o,
    .mem_addr_o,
    .mem_we_o,
    .mem_be_o,
    .mem_wdata_o,
    .mem_ack_i,
    .mem_rdata_i
  );
endmodule

// File: rtl/cfgdec_checker.sv
`timescale 1ns/1ps
module cfgdec_checker #(
  parameter int SLOT_W  = 5,
  parameter int FUNC_W  = 3,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int SEC_BIT = 24,
  localparam int SLOTS  = 1 << SLOT_W,
  localparam int FN_LO  = REG_W,
  localparam int SL_LO  = REG_W + FUNC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rsp_done_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic              mem_ack_i,
  input logic [SLOTS-1:0]  pop_vec
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R10
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R10
  AST_ACK_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> rsp_done_o && !mem_req_o); // R10
  AST_BE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || mem_be_o == 4'b0011 ||
                   mem_be_o == 4'b1100 || mem_be_o == 4'b1111)); // R7
  AST_ROOT_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && !mem_addr_o[SEC_BIT] |->
      (mem_addr_o[SL_LO-1:FN_LO] == '0) && pop_vec[mem_addr_o[SL_LO+SLOT_W-1:SL_LO]]); // R4
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R2
endmodule

bind cfg_window_decoder cfgdec_checker #(
  .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .SEC_BIT(SEC_BIT)
) i_cfgdec_checker (
  .clk_i, .rst_ni, .rsp_done_o, .mem_req_o, .mem_addr_o, .mem_be_o, .mem_ack_i,
  .pop_vec(pop_vec)
);

// File: tb/test_cfg_window_decoder.sv
`timescale 1ns/1ps
module test_cfg_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_reg = '0;
  logic [4:0]  req_slot = '0, pop_slot = '0;
  logic [2:0]  req_func = '0, req_size = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, mem_wdata, mem_rdata = '0;
  logic        rsp_done, pop_set = 1'b0, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;

  int total = 0, bad = 0;
  bit finished = 0;

  // captured downstream access
  bit          touched;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  logic        cap_we;
  logic [31:0] got_rdata;
  int          got_cyc;
  bit          pulse_ok;

  always #5 clk = ~clk;

  cfg_window_decoder i_cfg_window_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_bus_i(req_bus), .req_slot_i(req_slot),
    .req_func_i(req_func), .req_reg_i(req_reg), .req_size_i(req_size),
    .req_write_i(req_write), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rsp_rdata), .rsp_done_o(rsp_done),
    .pop_set_i(pop_set), .pop_slot_i(pop_slot),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hc3a5, a[15:0] ^ 16'h1e69};
  endfunction

  // downstream model: ack one cycle after request
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   = 1'b1;
      mem_rdata = pat(mem_addr);
      touched   = 1'b1;
      cap_addr  = mem_addr;
      cap_be    = mem_be;
      cap_we    = mem_we;
      cap_wdata = mem_wdata;
    end else begin
      mem_ack   = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] b, input logic [4:0] s, input logic [2:0] f,
                        input logic [7:0] r, input logic [2:0] sz, input logic we,
                        input logic [31:0] wd);
    @(negedge clk);
    req_bus = b; req_slot = s; req_func = f; req_reg = r; req_size = sz;
    req_write = we; req_wdata = wd; req_valid = 1'b1; touched = 0;
    @(negedge clk);
    req_valid = 1'b0;
    got_cyc = 1;
    while (!rsp_done && got_cyc < 40) begin
      @(negedge clk);
      got_cyc++;
    end
    got_rdata = rsp_rdata;
    @(negedge clk);
    pulse_ok = !rsp_done;
  endtask

  function automatic logic [31:0] exp_addr(input logic [7:0] b, input logic [4:0] s,
                                           input logic [2:0] f, input logic [7:0] r);
    logic [31:0] o;
    o = 32'(s) * 2048 + 32'(f) * 256 + 32'(r);
    if (b != 0) o = o + 32'h0100_0000 + 32'(b) * 65536;
    return o & ~32'd3;
  endfunction

  function automatic bit legal(input int sz, input int r);
    return (sz == 1) || (sz == 2 && r % 2 == 0) || (sz == 4 && r == 0);
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input int r);
    return sz == 1 ? 4'(1 << r) : sz == 2 ? 4'(3 << r) : 4'hf;
  endfunction

  function automatic logic [31:0] byte_mask(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = 8'hff;
    return m;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_done == 1'b0 && mem_req == 1'b0, "R1 reset outputs", {30'd0, rsp_done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R4: all unpopulated after reset
    for (int s = 0; s < 32; s++) begin
      do_req(8'd0, 5'(s), 3'd0, 8'h00, 3'd4, 1'b0, 32'h0);
      chk(!touched && got_rdata == 32'hffff_ffff, "R1 empty slot read", got_rdata, 32'hffff_ffff);
      chk(got_cyc == 1 && pulse_ok, "R10 local done timing", 32'(got_cyc), 32'd1);
    end

    // R6: populate even slots, one per cycle
    for (int s = 0; s < 32; s += 2) begin
      @(negedge clk);
      pop_set = 1'b1; pop_slot = 5'(s);
    end
    @(negedge clk);
    pop_set = 1'b0;

    // R2 / R4 / R6 / R8: bus 0 sweep over all slot and function pairs
    for (int s = 0; s < 32; s++) begin
      for (int f = 0; f < 8; f++) begin
        logic [31:0] ea;
        bit fwd;
        ea = exp_addr(8'd0, 5'(s), 3'(f), 8'h40);
        fwd = (s % 2 == 0) && (f == 0);
        do_req(8'd0, 5'(s), 3'(f), 8'h40, 3'd4, 1'b0, 32'h0);
        if (fwd) begin
          chk(touched && cap_addr == ea, "R2 bus0 address", cap_addr, ea);
          chk(got_rdata == pat(ea), "R8 word read data", got_rdata, pat(ea));
          chk(got_cyc == 2 && pulse_ok, "R10 forwarded done timing", 32'(got_cyc), 32'd2);
        end else begin
          chk(!touched && got_rdata == 32'hffff_ffff, "R4 blocked read", got_rdata, 32'hffff_ffff);
          if (f == 0) chk(!touched, "R6 odd slot stays empty", 32'(touched), 32'd0);
        end
      end
    end

    // R5: blocked writes never reach downstream
    for (int s = 0; s < 32; s++) begin
      do_req(8'd0, 5'(s), 3'((s % 2 == 0) ? 1 : 0), 8'h10, 3'd4, 1'b1, 32'hdead_beef);
      chk(!touched, "R5 blocked write dropped", 32'(touched), 32'd0);
    end

    // R7 / R8 / R9: every size code against every lane, reads and writes
    for (int sz = 0; sz < 8; sz++) begin
      for (int r = 0; r < 4; r++) begin
        logic [31:0] ea, ed, wd;
        logic [3:0]  eb;
        wd = 32'ha1b2_c3d4;
        ea = exp_addr(8'd0, 5'd2, 3'd0, 8'(8'h20 + r));
        eb = exp_be(sz, r);
        do_req(8'd0, 5'd2, 3'd0, 8'(8'h20 + r), 3'(sz), 1'b0, 32'h0);
        if (legal(sz, r)) begin
          ed = (pat(ea) >> (8 * r)) & (sz == 1 ? 32'hff : sz == 2 ? 32'hffff : 32'hffff_ffff);
          chk(touched && cap_be == eb && !cap_we, "R7 read byte enables", {28'd0, cap_be}, {28'd0, eb});
          chk(got_rdata == ed, "R8 right-justified read", got_rdata, ed);
        end else begin
          chk(!touched && got_rdata == 32'hffff_ffff, "R9 bad size read", got_rdata, 32'hffff_ffff);
        end
        do_req(8'd0, 5'd2, 3'd0, 8'(8'h20 + r), 3'(sz), 1'b1, wd);
        if (legal(sz, r)) begin
          logic [31:0] m, ew;
          m  = byte_mask(eb);
          ew = (wd << (8 * r)) & m;
          chk(touched && cap_we && cap_be == eb && cap_addr == ea, "R7 write enables", {28'd0, cap_be}, {28'd0, eb});
          chk((cap_wdata & m) == ew, "R7 write lane data", cap_wdata & m, ew);
        end else begin
          chk(!touched, "R9 bad size write dropped", 32'(touched), 32'd0);
        end
      end
    end

    // R3: every secondary bus, ignoring the populated map
    for (int b = 1; b < 256; b++) begin
      logic [31:0] ea;
      ea = exp_addr(8'(b), 5'(b % 32), 3'(b % 8), 8'h14);
      do_req(8'(b), 5'(b % 32), 3'(b % 8), 8'h14, 3'd4, 1'b0, 32'h0);
      chk(touched && cap_addr == ea, "R3 secondary bus address", cap_addr, ea);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule